// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Line Activity Events

This block recovers 8-bit asynchronous frames from a single serial wire. A free-running divider produces a sample tick at eight times the bit rate. The wire passes through a synchroniser and is then watched on every tick. A low level seen while the receiver is waiting marks the start of a frame. The data bits are sampled near their centres, least significant bit first, and the stop bit is checked one bit time after the last data sample.

A byte with a high stop bit goes out as a one-cycle pulse on the output port, provided the consumer is ready at that moment. If the consumer is not ready, the byte is dropped and an overrun pulse is raised instead. A low stop bit raises a framing-error pulse and discards the byte. The receiver then waits for the wire to go high again.

Three more outputs let a half-duplex transmit controller decide when it may take the wire: a busy pulse when activity starts, an idle pulse when the wire has stayed quiet after a frame, and a level flag that follows those two pulses.

Top module: `uart_idle_rx`

## Requirements
- R1: During and after synchronous reset, every event pulse and `out_valid` are 0 and `line_idle` is 1.
- R2: In the waiting state, the first tick that sees the synchronised line low raises `busy_evt` for one cycle and clears `line_idle`.
- R3: Ticks come every `CLKS_PER_TICK` clocks. Data is sampled 12 ticks after the start tick and then every 8 ticks, 8 samples in all. The first sample goes to bit 0 and the last to bit 7.
- R4: If the stop sample, taken 8 ticks after the last data sample, is high and `out_ready` is 1 on that clock, `out_valid` pulses for one cycle with the byte on `out_data`.
- R5: If the stop sample is high and `out_ready` is 0, no `out_valid` is given and `overrun_evt` pulses for one cycle.
- R6: If the stop sample is low, `ferr_evt` pulses for one cycle and no byte is delivered. No new frame starts until a tick sees the line high.
- R7: After a frame ends, a low line seen on a later tick starts a new frame at once, with no `busy_evt`.
- R8: After a frame ends, if 11 consecutive ticks see the line high, `idle_evt` pulses, `line_idle` is set to 1, and the next low level raises `busy_evt` again.
- R9: `rx_in` reaches the frame logic through a two-flop synchroniser, so every decision uses the line level from two clocks earlier.
- R10: At most one of `out_valid`, `busy_evt`, `ferr_evt`, `idle_evt` and `overrun_evt` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| out_ready | input | 1 | Consumer can take a byte this cycle |
| out_valid | output | 1 | One-cycle pulse: received byte present |
| out_data | output | DATA_BITS | Received byte |
| busy_evt | output | 1 | Pulse: line activity began |
| ferr_evt | output | 1 | Pulse: stop bit sampled low |
| idle_evt | output | 1 | Pulse: line quiet after a frame |
| overrun_evt | output | 1 | Pulse: byte dropped, consumer not ready |
| line_idle | output | 1 | Level: line currently considered idle |

## Verification
The hardest case to reach is a new start bit that arrives while the receiver is in the post-frame check window. There the frame must begin without a busy pulse, yet the idle count must not run out. The bench sends frames back to back with no gap, and it also holds the line low right after a bad stop bit, so that both the check window and the recovery state are entered and left. A behavioural cycle model runs alongside the design and follows the exact sample ticks, so a sampling offset of even one tick shows up as a data or event mismatch.

// File: rtl/uart_idle_rx_pkg.sv
package uart_idle_rx_pkg;

    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_SHIFT   = 3'd1,
        ST_STOP    = 3'd2,
        ST_RECOVER = 3'd3,
        ST_CHECK   = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic busy;
        logic ferr;
        logic idle;
        logic overrun;
    } rx_events_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/uirx_sync.sv
module uirx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/uirx_tick.sv
module uirx_tick
    import uart_idle_rx_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R3
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/uirx_frame.sv
module uirx_frame
    import uart_idle_rx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE  = 8,
    parameter int unsigned DATA_BITS   = 8,
    parameter int unsigned IDLE_CHECKS = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 rx_s,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [DATA_BITS-1:0] out_data,
    output rx_events_t           ev,
    output logic                 line_idle
);
    localparam int unsigned FIRST_SAMPLE = OVERSAMPLE + OVERSAMPLE / 2;
    localparam int unsigned TW = cnt_width(FIRST_SAMPLE);
    localparam int unsigned BW = cnt_width(DATA_BITS);
    localparam int unsigned IW = cnt_width(IDLE_CHECKS);
    localparam logic [TW-1:0] LOAD_FIRST = TW'(FIRST_SAMPLE - 1);
    localparam logic [TW-1:0] LOAD_BIT   = TW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] LAST_BIT   = BW'(DATA_BITS - 1);
    localparam logic [IW-1:0] LAST_IDLE  = IW'(IDLE_CHECKS - 1);

    rx_state_e            state;
    logic [TW-1:0]        tick_left;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic [IW-1:0]        idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT;
            tick_left <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            idle_cnt  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            ev        <= '0;
            line_idle <= 1'b1;
        end else begin
            out_valid <= 1'b0;
            ev        <= '0;
            if (tick) begin
                unique case (state)
                    ST_WAIT: begin
                        if (!rx_s) begin
                            ev.busy   <= 1'b1;
                            line_idle <= 1'b0;
                            state     <= ST_SHIFT;
                            tick_left <= LOAD_FIRST;
                            bit_idx   <= '0;
                        end
                    end
                    ST_SHIFT: begin
                        if (tick_left == '0) begin
                            shreg     <= {rx_s, shreg[DATA_BITS-1:1]};
                            tick_left <= LOAD_BIT;
                            if (bit_idx == LAST_BIT) state <= ST_STOP;
                            else bit_idx <= bit_idx + 1'b1;
                        end else begin
                            tick_left <= tick_left - 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tick_left == '0) begin
                            if (rx_s) begin
                                if (out_ready) begin
                                    out_valid <= 1'b1;
                                    out_data  <= shreg;
                                end else begin
                                    ev.overrun <= 1'b1;
                                end
                                state    <= ST_CHECK;
                                idle_cnt <= '0;
                            end else begin
                                ev.ferr <= 1'b1;
                                state   <= ST_RECOVER;
                            end
                        end else begin
                            tick_left <= tick_left - 1'b1;
                        end
                    end
                    ST_RECOVER: begin
                        if (rx_s) begin
                            state    <= ST_CHECK;
                            idle_cnt <= '0;
                        end
                    end
                    ST_CHECK: begin
                        if (!rx_s) begin
                            state     <= ST_SHIFT;
                            tick_left <= LOAD_FIRST;
                            bit_idx   <= '0;
                        end else if (idle_cnt == LAST_IDLE) begin
                            ev.idle   <= 1'b1;
                            line_idle <= 1'b1;
                            state     <= ST_WAIT;
                        end else begin
                            idle_cnt <= idle_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_WAIT;
                endcase
            end
        end
    end

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.busy, ev.ferr, ev.idle, ev.overrun, out_valid}));

    // R4
    valid_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(out_ready));

    // R8
    idle_flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line_idle) |-> ev.idle);

    // R2
    busy_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ev.busy |-> !line_idle);

    // R6
    recover_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && !rx_s) |=> (state == ST_RECOVER));
endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx
    import uart_idle_rx_pkg::*;
#(
    parameter int unsigned CLKS_PER_TICK = 4,
    parameter int unsigned OVERSAMPLE    = 8,
    parameter int unsigned DATA_BITS     = 8,
    parameter int unsigned IDLE_CHECKS   = 11,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_in,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 busy_evt,
    output logic                 ferr_evt,
    output logic                 idle_evt,
    output logic                 overrun_evt,
    output logic                 line_idle
);
    logic       rx_s;
    logic       tick;
    rx_events_t ev;

    uirx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_in),
        .q_sync  (rx_s)
    );

    uirx_tick #(.DIV(CLKS_PER_TICK)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    uirx_frame #(
        .OVERSAMPLE  (OVERSAMPLE),
        .DATA_BITS   (DATA_BITS),
        .IDLE_CHECKS (IDLE_CHECKS)
    ) i_frame (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .rx_s      (rx_s),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ev        (ev),
        .line_idle (line_idle)
    );

    assign busy_evt    = ev.busy;
    assign ferr_evt    = ev.ferr;
    assign idle_evt    = ev.idle;
    assign overrun_evt = ev.overrun;
endmodule

// File: tb/test_uart_idle_rx.sv
module test_uart_idle_rx;
    localparam int DIV = 4;
    localparam int OS  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_drv = 1'b1;
    logic       rdy_drv = 1'b1;
    logic       out_valid, busy_evt, ferr_evt, idle_evt, overrun_evt, line_idle;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_idle_rx i_uart_idle_rx (
        .clk         (clk),
        .rst         (rst),
        .rx_in       (rx_drv),
        .out_ready   (rdy_drv),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .busy_evt    (busy_evt),
        .ferr_evt    (ferr_evt),
        .idle_evt    (idle_evt),
        .overrun_evt (overrun_evt),
        .line_idle   (line_idle)
    );

    // Behavioural reference: ticks counted from reset, frame position as
    // a tick offset from the start tick.
    int   clk_since_rst;
    logic s1m, s2m;
    int   mode;        // 0 wait, 1 in frame, 2 recover, 3 post-frame check
    int   toff;
    int   highs;
    logic [7:0] mbyte;
    logic e_valid, e_busy, e_ferr, e_idle, e_ovr, e_flag;
    logic [7:0] e_data;

    always @(posedge clk) begin
        if (rst) begin
            clk_since_rst = 0;
            s1m = 1'b1; s2m = 1'b1;
            mode = 0; toff = 0; highs = 0; mbyte = 8'h00;
            e_valid = 0; e_busy = 0; e_ferr = 0; e_idle = 0; e_ovr = 0;
            e_flag = 1; e_data = 8'h00;
        end else begin
            logic line;
            logic is_tick;
            is_tick = ((clk_since_rst % DIV) == DIV - 1);
            clk_since_rst++;
            line = s2m;
            s2m = s1m;
            s1m = rx_drv;
            e_valid = 0; e_busy = 0; e_ferr = 0; e_idle = 0; e_ovr = 0;
            if (is_tick) begin
                if (mode == 0) begin
                    if (!line) begin
                        e_busy = 1; e_flag = 0; mode = 1; toff = 0;
                    end
                end else if (mode == 1) begin
                    toff++;
                    if (toff == 12 + 8 * 8) begin
                        if (line) begin
                            if (rdy_drv) begin e_valid = 1; e_data = mbyte; end
                            else e_ovr = 1;
                            mode = 3; highs = 0;
                        end else begin
                            e_ferr = 1; mode = 2;
                        end
                    end else if (toff >= 12 && ((toff - 12) % 8) == 0) begin
                        mbyte[(toff - 12) / 8] = line;
                    end
                end else if (mode == 2) begin
                    if (line) begin mode = 3; highs = 0; end
                end else begin
                    if (!line) begin
                        mode = 1; toff = 0;
                    end else begin
                        highs++;
                        if (highs == 11) begin
                            e_idle = 1; e_flag = 1; mode = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Event counters at the ports
    int n_valid = 0, n_busy = 0, n_ferr = 0, n_idle = 0, n_ovr = 0;
    logic [7:0] last_data = 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            chk(out_valid == e_valid, "R4", "out_valid", out_valid, e_valid);
            if (e_valid) chk(out_data == e_data, "R3", "out_data", out_data, e_data);
            chk(busy_evt == e_busy, "R2/R7", "busy_evt", busy_evt, e_busy);
            chk(ferr_evt == e_ferr, "R6", "ferr_evt", ferr_evt, e_ferr);
            chk(idle_evt == e_idle, "R8", "idle_evt", idle_evt, e_idle);
            chk(overrun_evt == e_ovr, "R5", "overrun_evt", overrun_evt, e_ovr);
            chk(line_idle == e_flag, "R8", "line_idle", line_idle, e_flag);
            chk($countones({out_valid, busy_evt, ferr_evt, idle_evt, overrun_evt}) <= 1,
                "R10", "event count", $countones({out_valid, busy_evt, ferr_evt, idle_evt, overrun_evt}), 1);
            if (out_valid) begin n_valid++; last_data = out_data; end
            if (busy_evt) n_busy++;
            if (ferr_evt) n_ferr++;
            if (idle_evt) n_idle++;
            if (overrun_evt) n_ovr++;
        end
    end

    task automatic hold(input logic v, input int ticks);
        rx_drv = v;
        repeat (ticks * DIV) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        hold(1'b0, OS);
        for (int i = 0; i < 8; i++) hold(b[i], OS);
        hold(stop, OS);
    endtask

    initial begin
        int v0, b0, i0, f0, o0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(out_valid == 0 && busy_evt == 0 && ferr_evt == 0 && idle_evt == 0 && overrun_evt == 0,
            "R1", "events in reset", {out_valid, busy_evt, ferr_evt, idle_evt, overrun_evt}, 0);
        chk(line_idle == 1, "R1", "line_idle in reset", line_idle, 1);
        rst = 1'b0;
        repeat (7) @(negedge clk);
        hold(1'b1, 5);

        // R2 R3 R4 R8: single frame then idle
        v0 = n_valid; b0 = n_busy; i0 = n_idle;
        send(8'hA5, 1'b1);
        hold(1'b1, 30);
        chk(n_busy - b0 == 1, "R2", "busy pulses", n_busy - b0, 1);
        chk(n_valid - v0 == 1, "R4", "bytes", n_valid - v0, 1);
        chk(last_data == 8'hA5, "R3", "byte value", last_data, 8'hA5);
        chk(n_idle - i0 == 1, "R8", "idle pulses", n_idle - i0, 1);
        chk(line_idle == 1, "R8", "flag after idle", line_idle, 1);

        // R7: back to back frames, only one busy pulse
        v0 = n_valid; b0 = n_busy; i0 = n_idle;
        send(8'h3C, 1'b1);
        send(8'hC3, 1'b1);
        hold(1'b1, 30);
        chk(n_busy - b0 == 1, "R7", "busy pulses back to back", n_busy - b0, 1);
        chk(n_valid - v0 == 2, "R7", "bytes back to back", n_valid - v0, 2);
        chk(last_data == 8'hC3, "R3", "second byte", last_data, 8'hC3);
        chk(n_idle - i0 == 1, "R8", "idle once", n_idle - i0, 1);

        // R5: consumer not ready
        v0 = n_valid; o0 = n_ovr;
        rdy_drv = 1'b0;
        send(8'h55, 1'b1);
        hold(1'b1, 30);
        rdy_drv = 1'b1;
        chk(n_ovr - o0 == 1, "R5", "overrun pulses", n_ovr - o0, 1);
        chk(n_valid - v0 == 0, "R5", "dropped byte", n_valid - v0, 0);

        // R6: bad stop bit, line held low afterwards
        v0 = n_valid; b0 = n_busy; f0 = n_ferr; i0 = n_idle;
        send(8'h81, 1'b0);
        hold(1'b0, 40);
        chk(line_idle == 0, "R6", "flag while held low", line_idle, 0);
        hold(1'b1, 30);
        chk(n_ferr - f0 == 1, "R6", "ferr pulses", n_ferr - f0, 1);
        chk(n_valid - v0 == 0, "R6", "no byte on ferr", n_valid - v0, 0);
        chk(n_busy - b0 == 1, "R6", "no restart while low", n_busy - b0, 1);
        chk(n_idle - i0 == 1, "R8", "idle after recovery", n_idle - i0, 1);

        // R3 R9: extreme patterns back to back
        v0 = n_valid;
        send(8'h00, 1'b1);
        send(8'hFF, 1'b1);
        send(8'h01, 1'b1);
        hold(1'b1, 30);
        chk(n_valid - v0 == 3, "R9", "bytes extreme", n_valid - v0, 3);
        chk(last_data == 8'h01, "R3", "lsb first", last_data, 8'h01);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule